// File: doc/BRIEF.md
# Collision Detect and Heartbeat Generator

This block drives the media-independent interface collision output. In half-duplex operation it raises the collision signal whenever the local transmitter and the receive path are busy at the same time. When full duplex is selected it holds the output low. A self-test mode makes the collision output follow transmit enable after a short, fixed delay. This lets a MAC check its collision handling without a second station on the wire.

At 10 Mb/s in half duplex, the block also produces a heartbeat after each frame. This is a signal-quality pulse of fixed length on the collision output, and it starts a fixed gap after transmit enable falls. A separate disable input suppresses the heartbeat. All delays and widths are counted in bit times, using a one-cycle bit-time tick that the surrounding logic supplies. Every control bit arrives as a plain input level.

Top module: `col_sqe_top`

## Requirements
- R1: In half duplex, while `tx_en_i` and `rx_active_i` are both high, `col_o` is high one clock later. It stays high for as long as the overlap lasts.
- R2: While `full_duplex_i` is high, `col_o` is low one clock later, whatever the overlap, test and heartbeat sources are doing.
- R3: With `col_test_i` high, a rise of `tx_en_i` appears on `col_o` after TEST_DLY bit-time ticks (default 2). The limit is 512 bit times.
- R4: With `col_test_i` high, a fall of `tx_en_i` removes test collision from `col_o` after TEST_DLY bit-time ticks (default 2). The limit is 4 bit times.
- R5: With `speed_10_i` high, half duplex and `sqe_dis_i` low, a fall of `tx_en_i` is followed by SQE_GAP ticks (default 20) of quiet. After that, `col_o` is high for SQE_LEN ticks (default 10).
- R6: While `sqe_dis_i` is high, no heartbeat pulse is produced, and a pending one is dropped.
- R7: If `tx_en_i` rises during the heartbeat gap or pulse, the heartbeat is cancelled at once.
- R8: No heartbeat is produced with `speed_10_i` low (100 Mb/s).
- R9: During reset and in the first cycle after it, `col_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_active_i | input | 1 | Receive activity from the receive path |
| full_duplex_i | input | 1 | 1 selects full duplex |
| speed_10_i | input | 1 | 1 selects 10 Mb/s, 0 selects 100 Mb/s |
| col_test_i | input | 1 | Collision self-test enable |
| sqe_dis_i | input | 1 | 1 suppresses the heartbeat pulse |
| col_o | output | 1 | Collision output |

## Verification
The assertions check on every cycle that full duplex silences the output. They also check that an overlap raises it, and that transmit enable, the disable input or 100 Mb/s mode kill the heartbeat pulse. A further check is that the test path and the pulse start only on a bit-time tick. The exact latencies of the test path and the gap and width of the heartbeat can only be shown by the bench's scenarios. The same holds for cancellation in mid-gap and mid-pulse. In those scenarios a behavioural model predicts the output on every clock.

// File: rtl/col_sqe_pkg.sv
package col_sqe_pkg;
  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_GAP   = 2'd1,
    SQE_PULSE = 2'd2
  } sqe_state_e;
endpackage

// File: rtl/col_test_delay.sv
module col_test_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_en_i,
  output logic test_o
);
  logic [DLY-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else if (tick_i) begin
      dly_q[0] <= tx_en_i;
      for (int i = 1; i < int'(DLY); i++) dly_q[i] <= dly_q[i-1];
    end
  end

  assign test_o = dly_q[DLY-1];

  // R3
  test_rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_o) |-> $past(tick_i));
  // R4
  test_fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(test_o) |-> $past(tick_i));
endmodule

// File: rtl/col_sqe_timer.sv
module col_sqe_timer
  import col_sqe_pkg::*;
#(
  parameter int unsigned GAP = 20,
  parameter int unsigned LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_en_i,
  input  logic enable_i,
  output logic pulse_o
);
  localparam int unsigned MaxCnt = (GAP > LEN) ? GAP : LEN;
  localparam int unsigned CntW   = $clog2(MaxCnt + 1);
  localparam logic [CntW-1:0] GapLast = CntW'(GAP - 1);
  localparam logic [CntW-1:0] LenLast = CntW'(LEN - 1);

  sqe_state_e     state_q;
  logic [CntW-1:0] cnt_q;
  logic            tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQE_IDLE;
      cnt_q   <= '0;
      tx_q    <= 1'b0;
    end else begin
      tx_q <= tx_en_i;
      if (tx_en_i || !enable_i) begin
        state_q <= SQE_IDLE;
        cnt_q   <= '0;
      end else if (tx_q) begin
        // falling edge of transmit enable arms the heartbeat
        state_q <= SQE_GAP;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          SQE_GAP: begin
            if (cnt_q == GapLast) begin
              state_q <= SQE_PULSE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          SQE_PULSE: begin
            if (cnt_q == LenLast) begin
              state_q <= SQE_IDLE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign pulse_o = (state_q == SQE_PULSE);

  // R7
  sqe_cancel_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> !pulse_o);
  // R6
  sqe_cancel_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !pulse_o);
  // R5
  sqe_start_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(tick_i));
endmodule

// File: rtl/col_sqe_top.sv
module col_sqe_top #(
  parameter int unsigned TEST_DLY = 2,
  parameter int unsigned SQE_GAP  = 20,
  parameter int unsigned SQE_LEN  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic tx_en_i,
  input  logic rx_active_i,
  input  logic full_duplex_i,
  input  logic speed_10_i,
  input  logic col_test_i,
  input  logic sqe_dis_i,
  output logic col_o
);
  logic test_col;
  logic sqe_pulse;
  logic sqe_en;
  logic col_d;

  assign sqe_en = speed_10_i && !full_duplex_i && !sqe_dis_i;

  col_test_delay #(.DLY(TEST_DLY)) u_test (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (bit_tick_i),
    .tx_en_i (tx_en_i),
    .test_o  (test_col)
  );

  col_sqe_timer #(.GAP(SQE_GAP), .LEN(SQE_LEN)) u_sqe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (bit_tick_i),
    .tx_en_i  (tx_en_i),
    .enable_i (sqe_en),
    .pulse_o  (sqe_pulse)
  );

  assign col_d = !full_duplex_i &&
                 ((tx_en_i && rx_active_i) || (col_test_i && test_col) || sqe_pulse);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_o <= 1'b0;
    else         col_o <= col_d;
  end

  // R2
  fdx_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_duplex_i |=> !col_o);
  // R1
  overlap_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && rx_active_i && !full_duplex_i) |=> col_o);
  // R8
  no_sqe_100m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !speed_10_i |=> !sqe_pulse);
endmodule

// File: tb/col_sqe_top_tb_top.sv
module col_sqe_top_tb_top;
  localparam int TEST_DLY = 2;
  localparam int SQE_GAP  = 20;
  localparam int SQE_LEN  = 10;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tx_en = 1'b0, rx_act = 1'b0, fdx = 1'b0, spd10 = 1'b0, ctest = 1'b0, sdis = 1'b0;
  logic col;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R9";
  bit exp_col = 1'b0;
  int cyc = 0;
  int high_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  col_sqe_top #(.TEST_DLY(TEST_DLY), .SQE_GAP(SQE_GAP), .SQE_LEN(SQE_LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .tx_en_i(tx_en),
    .rx_active_i(rx_act), .full_duplex_i(fdx), .speed_10_i(spd10),
    .col_test_i(ctest), .sqe_dis_i(sdis), .col_o(col)
  );

  // behavioural reference model
  bit hist[$];
  bit armed = 1'b0;
  int ticks = 0;
  bit tx_prev = 1'b0;

  initial for (int i = 0; i < TEST_DLY; i++) hist.push_back(1'b0);

  always @(posedge clk) begin
    bit pulse;
    if (!rst_n) begin
      exp_col = 1'b0;
      armed = 1'b0; ticks = 0; tx_prev = 1'b0;
      hist.delete();
      for (int i = 0; i < TEST_DLY; i++) hist.push_back(1'b0);
    end else begin
      pulse = armed && ticks >= SQE_GAP && ticks < SQE_GAP + SQE_LEN;
      exp_col = !fdx && ((tx_en && rx_act) || (ctest && hist[0]) || pulse);
      if (tick) begin
        hist.push_back(tx_en);
        void'(hist.pop_front());
      end
      if (tx_en || !spd10 || fdx || sdis) begin
        armed = 1'b0;
      end else if (tx_prev) begin
        armed = 1'b1; ticks = 0;
      end else if (armed && tick) begin
        ticks++;
        if (ticks >= SQE_GAP + SQE_LEN) armed = 1'b0;
      end
      tx_prev = tx_en;
    end
  end

  // tick generator and per-cycle compare, away from the active edge
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % TICK_DIV) == 0;
    if (rst_n && !done) begin
      n_tests++;
      if (col !== exp_col) begin
        n_fail++;
        $display("FAIL %s cyc %0d: col_o=%b expected %b", cur_req, cyc, col, exp_col);
      end
      if (col === 1'b1) high_cnt++;
    end
  end

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, bit act, bit expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, expv);
    end
  endtask

  task automatic check_int(string req, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  // watchdog
  initial begin
    wait_clk(100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    check("R9", col, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", col, 1'b0);
    wait_clk(5);

    // R1 overlap at 100M half duplex
    cur_req = "R1";
    tx_en = 1'b1; wait_clk(5); rx_act = 1'b1; wait_clk(20);
    check("R1", col, 1'b1);
    rx_act = 1'b0; wait_clk(3); tx_en = 1'b0; wait_clk(10);

    // R2 full duplex silences overlap and test mode
    cur_req = "R2"; fdx = 1'b1; ctest = 1'b1;
    tx_en = 1'b1; rx_act = 1'b1; wait_clk(30);
    check("R2", col, 1'b0);
    tx_en = 1'b0; rx_act = 1'b0; wait_clk(20);
    fdx = 1'b0; wait_clk(20);

    // R3 R4 test mode echo
    cur_req = "R3";
    tx_en = 1'b1; wait_clk(40);
    check("R3", col, 1'b1);
    cur_req = "R4";
    tx_en = 1'b0; wait_clk(40);
    check("R4", col, 1'b0);
    ctest = 1'b0; wait_clk(10);

    // R5 heartbeat at 10M
    cur_req = "R5"; spd10 = 1'b1;
    tx_en = 1'b1; wait_clk(30);
    high_cnt = 0;
    tx_en = 1'b0; wait_clk(200);
    check_int("R5", high_cnt, SQE_LEN * TICK_DIV);

    // R6 disabled heartbeat
    cur_req = "R6"; sdis = 1'b1;
    tx_en = 1'b1; wait_clk(30);
    high_cnt = 0;
    tx_en = 1'b0; wait_clk(200);
    check_int("R6", high_cnt, 0);
    // disable raised mid-pulse
    sdis = 1'b0;
    tx_en = 1'b1; wait_clk(10); tx_en = 1'b0;
    wait_clk((SQE_GAP + 3) * TICK_DIV);
    sdis = 1'b1; wait_clk(2);
    check("R6", col, 1'b0);
    wait_clk(100); sdis = 1'b0; wait_clk(10);

    // R7 cancel during gap and during pulse
    cur_req = "R7";
    tx_en = 1'b1; wait_clk(10); tx_en = 1'b0;
    wait_clk(40);
    tx_en = 1'b1; wait_clk(10);
    check("R7", col, 1'b0);
    tx_en = 1'b0; wait_clk(200);
    tx_en = 1'b1; wait_clk(10); tx_en = 1'b0;
    wait_clk((SQE_GAP + 3) * TICK_DIV);
    check("R7", col, 1'b1);
    tx_en = 1'b1; wait_clk(2);
    check("R7", col, 1'b0);
    wait_clk(10);
    tx_en = 1'b0; wait_clk(200);

    // R8 no heartbeat at 100M
    cur_req = "R8"; spd10 = 1'b0;
    tx_en = 1'b1; wait_clk(30);
    high_cnt = 0;
    tx_en = 1'b0; wait_clk(200);
    check_int("R8", high_cnt, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule